// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs single-byte memory and I/O transfers for an 8-bit processor core that addresses 64 KiB. The low twelve address bits leave on dedicated lines. The top four address bits share the 8-bit bidirectional data bus. During a one-clock address strobe, that bus carries the upper address nibble and four cycle-status bits: read/write, instruction fetch, delay operand fetch and halt. One setup clock follows. The block then drives an active-low read or write strobe for a minimum number of clocks. An external hold input can stretch that strobe for slow devices.

The core raises a request with the address, the write data and the status qualifiers. These values are latched when the request is accepted. The core receives a one-clock acknowledge, together with the read data captured at the strobe's trailing edge. The pad tri-state is represented by two output enables, one for the address lines and one for the data bus. Arbitration for the bus lives in a different block.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is asserted, and in idle, all three strobes are high, both output enables are low and the acknowledge is low.
- R2: A request accepted in idle (req_i high at a clock edge) produces an address strobe that is low for exactly one clock, starting the next clock. While it is low, the address lines carry address bits 11:0 and the address enable is high.
- R3: While the address strobe is low, data bus bits 3:0 carry address bits 15:12, with bit 3 as the most significant.
- R4: While the address strobe is low, data bus bit 4 is 1 for a read and 0 for a write, and bit 5 is 1 for an instruction first-byte fetch.
- R5: While the address strobe is low, data bus bit 6 is 1 for a delay operand fetch and bit 7 is 1 when a halt has executed.
- R6: Exactly one setup clock follows the address strobe. In it, the address is still driven, all strobes are high and the data bus is floated.
- R7: A read strobe stays low for at least MIN_STROBE clocks, with the data bus floated. The data bus value present at its trailing (rising) edge is returned on rdata_o.
- R8: A write strobe stays low for at least MIN_STROBE clocks, with the data bus enabled and carrying the latched write data.
- R9: hold_ni is sampled at each strobe clock once the minimum is met. If it is low, the strobe remains low for another clock, until it is sampled high.
- R10: After the trailing edge, the address lines float until the next address strobe. The data bus is enabled only during the address strobe and the write strobe.
- R11: ack_o is high for exactly the one clock after the trailing edge.
- R12: req_i is ignored while a transfer is in progress. Changes to addr_i or wdata_i after acceptance do not reach the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request from the core |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Transfer address |
| wdata_i | input | 8 | Write data |
| ifetch_i | input | 1 | Instruction first-byte fetch qualifier |
| dly_i | input | 1 | Delay operand fetch qualifier |
| halt_i | input | 1 | Halt-executed qualifier |
| ack_o | output | 1 | Transfer complete, one clock |
| rdata_o | output | 8 | Captured read data |
| ad_o | output | 12 | Dedicated low address lines |
| ad_oe_o | output | 1 | Address line output enable |
| db_o | output | 8 | Data bus output value |
| db_oe_o | output | 1 | Data bus output enable |
| db_i | input | 8 | Data bus input value |
| ads_no | output | 1 | Address strobe, active low |
| rds_no | output | 1 | Read strobe, active low |
| wds_no | output | 1 | Write strobe, active low |
| hold_ni | input | 1 | Strobe stretch request, active low |

## Verification
The bench builds the block with its defaults: a 16-bit address, 12 dedicated lines and MIN_STROBE of 2. With a two-clock strobe, each transfer takes a handful of clocks, so one run can cover reads, writes, stretches of zero to five extra clocks and back-to-back transfers. The bench changes the data bus input on every clock. A read that captures one clock early or late therefore returns a visibly different byte. Stray requests and address changes made during a transfer show whether the latched request is really held.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STRB,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic we;
    logic ifetch;
    logic dly;
    logic halt;
  } cyc_kind_t;
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int MIN_STROBE = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   hold_ni,
  output phase_e phase_o,
  output logic   accept_o,
  output logic   trail_o
);
  localparam int CNT_W = $clog2(MIN_STROBE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_STROBE - 1);

  phase_e ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic min_met;

  assign min_met  = (cnt_q >= LAST);
  assign accept_o = (ph_q == PH_IDLE) && req_i;
  assign trail_o  = (ph_q == PH_STRB) && min_met && hold_ni;
  assign phase_o  = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE:  if (accept_o) ph_q <= PH_ADDR;
        PH_ADDR:  ph_q <= PH_SETUP;
        PH_SETUP: begin
          ph_q  <= PH_STRB;
          cnt_q <= '0;
        end
        PH_STRB: begin
          if (trail_o) ph_q <= PH_DONE;
          else if (!min_met) cnt_q <= cnt_q + 1'b1;
        end
        PH_DONE:  ph_q <= PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_seq_req_latch.sv
module bus_seq_req_latch
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  cyc_kind_t         kind_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output cyc_kind_t         kind_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      kind_o  <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      kind_o  <= kind_i;
    end
  end
endmodule

// File: rtl/bus_seq_rd_cap.sv
module bus_seq_rd_cap #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trail_i,
  input  logic [DATA_W-1:0] db_i,
  output logic [DATA_W-1:0] rdata_o
);
  // sampled at the edge where the strobe rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (trail_i) rdata_o <= db_i;
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LOW_W      = 12,
  parameter int DATA_W     = 8,
  parameter int MIN_STROBE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ifetch_i,
  input  logic              dly_i,
  input  logic              halt_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LOW_W-1:0]  ad_o,
  output logic              ad_oe_o,
  output logic [DATA_W-1:0] db_o,
  output logic              db_oe_o,
  input  logic [DATA_W-1:0] db_i,
  output logic              ads_no,
  output logic              rds_no,
  output logic              wds_no,
  input  logic              hold_ni
);
  localparam int HI_W = ADDR_W - LOW_W;

  phase_e            phase;
  logic              accept, trail;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  cyc_kind_t         kind_in, kind_q;
  logic [DATA_W-1:0] stat_byte;
  logic              in_addr, in_strb;

  assign kind_in = '{we: we_i, ifetch: ifetch_i, dly: dly_i, halt: halt_i};

  bus_seq_fsm #(.MIN_STROBE(MIN_STROBE)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .hold_ni  (hold_ni),
    .phase_o  (phase),
    .accept_o (accept),
    .trail_o  (trail)
  );

  bus_seq_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .kind_i   (kind_in),
    .addr_o   (addr_q),
    .wdata_o  (wdata_q),
    .kind_o   (kind_q)
  );

  bus_seq_rd_cap #(.DATA_W(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trail_i (trail),
    .db_i    (db_i),
    .rdata_o (rdata_o)
  );

  assign in_addr = (phase == PH_ADDR);
  assign in_strb = (phase == PH_STRB);

  // status nibble above the upper address nibble; bit 4 set means input cycle
  assign stat_byte = DATA_W'({kind_q.halt, kind_q.dly, kind_q.ifetch, ~kind_q.we,
                              addr_q[ADDR_W-1 -: HI_W]});

  assign ads_no  = ~in_addr;
  assign rds_no  = ~(in_strb && !kind_q.we);
  assign wds_no  = ~(in_strb && kind_q.we);
  assign ad_oe_o = in_addr || (phase == PH_SETUP) || in_strb;
  assign ad_o    = ad_oe_o ? addr_q[LOW_W-1:0] : '0;
  assign db_oe_o = in_addr || (in_strb && kind_q.we);
  assign db_o    = in_addr ? stat_byte : (db_oe_o ? wdata_q : '0);
  assign ack_o   = (phase == PH_DONE);
endmodule

module bus_cycle_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ads_no,
  input logic rds_no,
  input logic wds_no,
  input logic ad_oe_o,
  input logic db_oe_o,
  input logic ack_o,
  input logic hold_ni
);
  logic strb;
  assign strb = !rds_no || !wds_no;

  AST_ADS_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_no |=> ads_no); // R2
  AST_ADDR_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_no || strb) |-> ad_oe_o); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!ads_no, !rds_no, !wds_no}) <= 1); // R7
  AST_DB_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_oe_o |-> (!ads_no || !wds_no)); // R10
  AST_HOLD_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb && $past(strb) && !hold_ni) |=> strb); // R9
  AST_ACK_AFTER_TRAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(strb) && !strb)); // R11
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R11
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ads_no  (ads_no),
  .rds_no  (rds_no),
  .wds_no  (wds_no),
  .ad_oe_o (ad_oe_o),
  .db_oe_o (db_oe_o),
  .ack_o   (ack_o),
  .hold_ni (hold_ni)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  localparam int MINS = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, we_i = 0, ifetch_i = 0, dly_i = 0, halt_i = 0, hold_ni = 1;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0, db_i = 8'h5a;
  logic ack_o, ad_oe_o, db_oe_o, ads_no, rds_no, wds_no;
  logic [7:0]  rdata_o, db_o;
  logic [11:0] ad_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ifetch_i(ifetch_i), .dly_i(dly_i), .halt_i(halt_i),
    .ack_o(ack_o), .rdata_o(rdata_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .db_o(db_o), .db_oe_o(db_oe_o), .db_i(db_i), .ads_no(ads_no),
    .rds_no(rds_no), .wds_no(wds_no), .hold_ni(hold_ni)
  );

  // reference model: phase number and strobe clock count, plus a request queue
  int m_ph = 0, m_k = 0;
  logic [7:0] m_rd = '0;
  typedef struct {logic we, ifetch, dly, halt; logic [15:0] a; logic [7:0] w;} rq_t;
  rq_t m_q[$];
  rq_t m_cur;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph <= 0; m_k <= 0; m_rd <= '0; m_q.delete();
    end else begin
      case (m_ph)
        0: if (req_i) begin
             m_q.push_back('{we_i, ifetch_i, dly_i, halt_i, addr_i, wdata_i});
             m_ph <= 1;
           end
        1: m_ph <= 2;
        2: begin m_ph <= 3; m_k <= 0; end
        3: if (m_k >= MINS - 1 && hold_ni) begin m_ph <= 4; m_rd <= db_i; end
           else m_k <= m_k + 1;
        4: begin m_ph <= 0; void'(m_q.pop_front()); end
        default: m_ph <= 0;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_ni) begin
      chk("R1 strobes in reset", {ads_no, rds_no, wds_no}, 3'b111);
      chk("R1 enables/ack in reset", {ad_oe_o, db_oe_o, ack_o}, 3'b000);
    end else begin
      if (m_q.size() > 0) m_cur = m_q[0];
      chk("R2 address strobe", ads_no, m_ph != 1);
      chk("R7 R9 read strobe", rds_no, !(m_ph == 3 && !m_cur.we));
      chk("R8 R9 write strobe", wds_no, !(m_ph == 3 && m_cur.we));
      chk("R10 address enable", ad_oe_o, m_ph >= 1 && m_ph <= 3);
      chk("R10 data enable", db_oe_o, m_ph == 1 || (m_ph == 3 && m_cur.we));
      chk("R11 acknowledge", ack_o, m_ph == 4);
      if (m_ph == 0) chk("R1 idle quiet", {ads_no, rds_no, wds_no, ad_oe_o, db_oe_o}, 5'b11100);
      if (m_ph >= 1 && m_ph <= 3) chk("R2 R12 low address", ad_o, m_cur.a[11:0]);
      if (m_ph == 1) begin
        chk("R3 upper address nibble", db_o[3:0], m_cur.a[15:12]);
        chk("R4 read/fetch flags", db_o[5:4], {m_cur.ifetch, !m_cur.we});
        chk("R5 delay/halt flags", db_o[7:6], {m_cur.halt, m_cur.dly});
      end
      if (m_ph == 2) chk("R6 setup clock", {ads_no, rds_no, wds_no, ad_oe_o, db_oe_o}, 5'b11110);
      if (m_ph == 3 && m_cur.we) chk("R8 R12 write data", db_o, m_cur.w);
      if (m_ph == 4 && !m_cur.we) chk("R7 read data", rdata_o, m_rd);
    end
    if (cyc > 20000 && !done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // data bus input changes every clock so capture timing is visible
  always @(negedge clk) db_i <= db_i + 8'd37;

  task automatic xfer(bit we, bit fi, bit dl, bit hl, logic [15:0] a, logic [7:0] w,
                      int extra, bit stray);
    @(negedge clk); #1;
    req_i = 1; we_i = we; ifetch_i = fi; dly_i = dl; halt_i = hl; addr_i = a; wdata_i = w;
    @(negedge clk); #1;
    req_i = 0;
    if (extra > 0) hold_ni = 0;
    if (stray) begin // R12 request and new fields mid-transfer
      @(negedge clk); #1;
      req_i = 1; addr_i = ~a; wdata_i = ~w; we_i = ~we;
      @(negedge clk); #1;
      req_i = 0;
      repeat (1 + extra) @(negedge clk);
    end else begin
      repeat (3 + extra) @(negedge clk);
    end
    #1 hold_ni = 1;
    for (int i = 0; i < 20 && !ack_o; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_ni = 1;
    repeat (2) @(negedge clk);
    xfer(0, 1, 0, 0, 16'hA123, 8'h00, 0, 0);
    xfer(1, 0, 0, 0, 16'h5FED, 8'hC3, 0, 0);
    xfer(0, 0, 1, 0, 16'h0FFF, 8'h00, 2, 0);
    xfer(1, 0, 0, 1, 16'hF000, 8'h3C, 5, 0);
    xfer(0, 1, 1, 1, 16'h8001, 8'h00, 1, 1);
    xfer(1, 1, 0, 0, 16'h7777, 8'hA5, 0, 1);
    for (int i = 0; i < 8; i++)
      xfer(i[0], i[1], i[2], i[0] ^ i[2], 16'(i * 16'h2345 + 16'h0101), 8'(i * 29), i % 4, i[1]);
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule